// File: doc/BRIEF.md
# Fractional 16x Baud Tick Generator

This block makes the 16x oversampling tick that a serial transmitter and receiver share. Software programs a clocks-per-bit count, rounded from clock/baud, as two register values. The low register holds the 4-bit remainder of that count in bits [15:12] and the low 8 bits of the integer field in bits [7:0]. The high register holds the upper bits of the integer field. The integer field is (clocks-per-bit / 16) - 1, so an integer field of 0 gives one clock per tick. That setting is the fastest rate allowed, clock/16.

Each tick period is (integer field + 1) clocks. Within every group of 16 ticks, a 4-bit accumulator picks exactly remainder-many ticks to be one clock longer and spreads them evenly. The time between bit-boundary pulses is therefore exactly clocks-per-bit. A load strobe captures both register values and restarts the tick and sub-bit counting from a clean boundary. Software only loads while the transmitter is empty. Dropping the enable holds the generator silent and cleared.

The sequencer has three states. ST_IDLE is entered on reset, on load and while the enable is low. It moves to ST_COUNT (transition "arm") on the first clock with the enable high and no load. ST_COUNT counts clocks of the base period. When the count reaches the integer field, it either emits a tick and stays in ST_COUNT ("tick"), or moves to ST_STRETCH if the accumulator carries ("stretch"). ST_STRETCH emits the tick one clock later and returns to ST_COUNT ("release"). Any state goes to ST_IDLE on load or when the enable is low ("clear").

Top module: `baud_tick_gen`

## Requirements
- R1: A load captures integer field = {div_hi, div_lo[7:0]} and fraction = div_lo[15:12]. div_lo[11:8] has no effect.
- R2: Consecutive ticks inside a group are separated by either integer+1 or integer+2 clocks.
- R3: Ticks are numbered k = 0..15 within a group. Tick k is stretched by one clock exactly when ((k*fraction) mod 16) + fraction >= 16. Each group therefore holds exactly fraction-many stretched ticks.
- R4: bit_end is high together with every 16th tick, and only then. The clocks between a restart and the first bit_end, and between consecutive bit_end pulses, equal 16*(integer+1)+fraction.
- R5: No tick is produced in the cycle a load is applied, nor in the cycle after it. With enable high, the first tick appears after the (integer+1)-th rising edge that follows the edge sampling the load. The tick and sub-bit counting restart at tick 0.
- R6: While enable is low, tick and bit_end stay low and all counting is cleared. The first tick after enable returns appears after the (integer+1)-th rising edge that follows the last edge sampling enable low.
- R7: With integer field 0 and fraction 0, a tick is produced on every clock.
- R8: During reset, tick and bit_end are low. Reset leaves a divisor of zero, so with enable high and no load the ticks run every clock after reset is released.
- R9: Changes on div_lo and div_hi without a load have no effect on the tick stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Generator enable |
| load | input | 1 | Capture divisor and restart counting |
| div_lo | input | 16 | Low divisor register: [15:12] fraction, [7:0] integer low bits |
| div_hi | input | 8 | High divisor register: integer upper bits |
| tick | output | 1 | One-clock 16x oversampling pulse |
| bit_end | output | 1 | One-clock pulse on every 16th tick |

## Verification
The load strobe or the end of a low-enable stretch sets the reference point. The first tick is due exactly integer+1 edges later, counted through the state register and the clock counter. Each later tick is due integer+1 edges after the previous one, plus one edge when the R3 rule picks that tick. bit_end is due in the same cycle as tick 16 of the group. The bench samples on the falling edge, after the rising edge that updated the registers and before any input change. It compares tick and bit_end in every cycle against a schedule computed from the stretch rule. It also measures bit periods and counts stretched intervals from the observed pulses.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_STRETCH = 2'd2
    } tick_state_t;

endpackage

// File: rtl/baud_div_latch.sv
module baud_div_latch #(
    parameter int INT_W    = 16,
    parameter int FRAC_W   = 4,
    parameter int LO_W     = 16,
    parameter int INT_LO_W = 8,
    parameter int FRAC_LSB = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [LO_W-1:0]           div_lo,
    input  logic [INT_W-INT_LO_W-1:0] div_hi,
    output logic [INT_W-1:0]          int_q,
    output logic [FRAC_W-1:0]         frac_q
);

    localparam int GAP_W = FRAC_LSB - INT_LO_W;

    // Reserved low-register bits between the two fields are never decoded.
    logic unused_gap_bits;
    assign unused_gap_bits = ^div_lo[INT_LO_W +: GAP_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q  <= '0;
            frac_q <= '0;
        end else if (load) begin
            int_q  <= {div_hi, div_lo[INT_LO_W-1:0]};
            frac_q <= div_lo[FRAC_LSB +: FRAC_W];
        end
    end

    // Captured divisor moves only on a load edge (R9).
    p_hold_without_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(int_q) && $stable(frac_q)));

endmodule

// File: rtl/baud_frac_acc.sv
module baud_frac_acc #(
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic [FRAC_W-1:0] frac,
    output logic              carry,
    output logic              last
);

    localparam logic [FRAC_W-1:0] ONE = FRAC_W'(1);

    logic [FRAC_W-1:0] acc;
    logic [FRAC_W-1:0] sub;
    logic [FRAC_W:0]   sum;

    assign sum   = {1'b0, acc} + {1'b0, frac};
    assign carry = sum[FRAC_W];
    assign last  = &sub;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            sub <= '0;
        end else if (clr) begin
            acc <= '0;
            sub <= '0;
        end else if (adv) begin
            acc <= sum[FRAC_W-1:0];
            sub <= sub + ONE;
        end
    end

    // A full group of additions returns the accumulator to zero (R3).
    p_group_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && last && !clr) |=> (acc == '0));

    // The sub-bit index restarts after the last tick of a group (R4).
    p_sub_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && last) |=> (sub == '0));

endmodule

// File: rtl/baud_tick_fsm.sv
module baud_tick_fsm
    import baud_tick_pkg::*;
#(
    parameter int INT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [INT_W-1:0] int_q,
    input  logic             carry,
    output logic             tick
);

    localparam logic [INT_W-1:0] ONE = INT_W'(1);

    tick_state_t      st, st_n;
    logic [INT_W-1:0] cnt, cnt_n;
    logic             at_end;

    assign at_end = (cnt == int_q);

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        if (clr) begin
            st_n  = ST_IDLE;
            cnt_n = '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    st_n  = ST_COUNT;
                    cnt_n = '0;
                end
                ST_COUNT: begin
                    if (at_end) begin
                        cnt_n = '0;
                        if (carry) st_n = ST_STRETCH;
                    end else begin
                        cnt_n = cnt + ONE;
                    end
                end
                ST_STRETCH: begin
                    st_n  = ST_COUNT;
                    cnt_n = '0;
                end
                default: begin
                    st_n  = ST_IDLE;
                    cnt_n = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        tick = 1'b0;
        if (!clr) begin
            unique case (st)
                ST_IDLE:    tick = 1'b0;
                ST_COUNT:   tick = at_end && !carry;
                ST_STRETCH: tick = 1'b1;
                default:    tick = 1'b0;
            endcase
        end
    end

    // Clock counter never passes the captured integer field (R2).
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= int_q);

    // A stretch lasts exactly one clock (R2).
    p_stretch_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STRETCH) |=> (st != ST_STRETCH));

    // A stretch only follows a full base period (R3).
    p_stretch_after_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STRETCH) |-> ($past(st) == ST_COUNT && $past(cnt) == $past(int_q)));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int INT_W    = 16,
    parameter int FRAC_W   = 4,
    parameter int LO_W     = 16,
    parameter int INT_LO_W = 8,
    parameter int FRAC_LSB = 12,
    parameter int HI_W     = INT_W - INT_LO_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            load,
    input  logic [LO_W-1:0] div_lo,
    input  logic [HI_W-1:0] div_hi,
    output logic            tick,
    output logic            bit_end
);

    logic [INT_W-1:0]  int_q;
    logic [FRAC_W-1:0] frac_q;
    logic              clr;
    logic              carry;
    logic              last;

    assign clr = load || !en;

    baud_div_latch #(
        .INT_W(INT_W), .FRAC_W(FRAC_W), .LO_W(LO_W),
        .INT_LO_W(INT_LO_W), .FRAC_LSB(FRAC_LSB)
    ) u_latch (
        .clk(clk), .rst_n(rst_n), .load(load),
        .div_lo(div_lo), .div_hi(div_hi),
        .int_q(int_q), .frac_q(frac_q)
    );

    baud_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(clr), .adv(tick),
        .frac(frac_q), .carry(carry), .last(last)
    );

    baud_tick_fsm #(.INT_W(INT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .int_q(int_q), .carry(carry), .tick(tick)
    );

    assign bit_end = tick && last;

    // Nothing ticks in the clock after the enable was low (R6).
    p_quiet_after_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tick);

    // Nothing ticks in the clock after a load (R5).
    p_gap_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !tick);

    // Two bit boundaries cannot be adjacent (R4).
    p_bitend_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |=> !bit_end);

endmodule

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        load = 1'b0;
    logic [15:0] div_lo = '0;
    logic [7:0]  div_hi = '0;
    logic        tick;
    logic        bit_end;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    baud_tick_gen dut (
        .clk(clk), .rst_n(rst_n), .en(en), .load(load),
        .div_lo(div_lo), .div_hi(div_hi), .tick(tick), .bit_end(bit_end)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R3 stretch rule for tick k of a group.
    function automatic int extra_at(input int k, input int fr);
        return ((((k * fr) % 16) + fr) >= 16) ? 1 : 0;
    endfunction

    function automatic int group_len(input int iv, input int fr);
        return 16 * (iv + 1) + fr;
    endfunction

    // Called right after the reference sample (t = 0).
    task automatic follow(input int iv, input int fr, input int ngroups,
                          input bit scramble, input string req);
        int t = 0;
        int k = 0;
        int next_t = iv + 1 + extra_at(0, fr);
        int prev_tick = 0;
        int prev_be = 0;
        int stretched = 0;
        int seen = 0;
        bit exp_tick;
        bit exp_be;
        while (seen < 16 * ngroups) begin
            @(negedge clk);
            t++;
            exp_tick = (t == next_t);
            exp_be = exp_tick && ((k % 16) == 15);
            check(tick == exp_tick, req, "tick", int'(tick), int'(exp_tick));
            check(bit_end == exp_be, "R4", "bit_end", int'(bit_end), int'(exp_be));
            if (tick) begin
                check((t - prev_tick == iv + 1) || (t - prev_tick == iv + 2),
                      "R2", "tick gap", t - prev_tick, iv + 1);
                if (t - prev_tick > iv + 1) stretched++;
                prev_tick = t;
                seen++;
            end
            if (bit_end) begin
                check(t - prev_be == group_len(iv, fr), "R4", "bit period",
                      t - prev_be, group_len(iv, fr));
                check(stretched == fr, "R3", "stretched ticks", stretched, fr);
                prev_be = t;
                stretched = 0;
            end
            if (exp_tick) begin
                k++;
                next_t = t + iv + 1 + extra_at(k % 16, fr);
            end
            if (t > 16 * ngroups * (iv + 2) + 8) begin
                check(1'b0, req, "tick count", seen, 16 * ngroups);
                seen = 16 * ngroups;
            end
            if (scramble && (t % 7 == 0)) begin
                div_lo = 16'($urandom);
                div_hi = 8'($urandom);
            end
        end
    endtask

    // Load with junk in the reserved bits [11:8] (R1); ends at t = 0.
    task automatic start(input int iv, input int fr);
        @(negedge clk);
        div_lo = {fr[3:0], 4'($urandom), iv[7:0]};
        div_hi = iv[15:8];
        load = 1'b1;
        @(negedge clk);
        check(tick == 1'b0, "R5", "tick in load cycle", int'(tick), 0);
        load = 1'b0;
    endtask

    task automatic off_window(input int iv, input int fr, input int len);
        @(negedge clk);
        en = 1'b0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            check(tick == 1'b0, "R6", "tick while off", int'(tick), 0);
            check(bit_end == 1'b0, "R6", "bit_end while off", int'(bit_end), 0);
            if (i % 3 == 0) div_lo = 16'($urandom);
        end
        div_lo = {fr[3:0], 4'h0, iv[7:0]};
        div_hi = iv[15:8];
        en = 1'b1;
        follow(iv, fr, 1, 1'b0, "R6");
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 190000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(tick == 1'b0, "R8", "tick in reset", int'(tick), 0);
            check(bit_end == 1'b0, "R8", "bit_end in reset", int'(bit_end), 0);
        end
        rst_n = 1'b1;
        follow(0, 0, 1, 1'b0, "R8");

        start(0, 0);   follow(0, 0, 2, 1'b0, "R7");
        start(0, 15);  follow(0, 15, 2, 1'b1, "R3");
        start(0, 1);   follow(0, 1, 1, 1'b0, "R3");
        start(1, 8);   follow(1, 8, 2, 1'b1, "R1");
        start(3, 5);   follow(3, 5, 1, 1'b0, "R5");
        off_window(3, 5, 12);
        start(300, 7); follow(300, 7, 1, 1'b1, "R1");
        start(258, 0); follow(258, 0, 1, 1'b0, "R1");

        // Reload in mid-group, then restart counting (R5).
        start(6, 11);
        for (int i = 0; i < 40; i++) @(negedge clk);
        start(2, 9);   follow(2, 9, 2, 1'b1, "R5");

        for (int n = 0; n < 20; n++) begin
            int iv = int'($urandom % 41);
            int fr = int'($urandom % 16);
            start(iv, fr);
            follow(iv, fr, 2, 1'b1, "R9");
            if (n % 5 == 4) off_window(iv, fr, 5);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule